// File: doc/BRIEF.md
# Stack-Code Hyperblock Grouper

This unit sits after the decoder of a stack-machine front end. It accepts decoded postfix instructions one at a time and packs them into hyperblocks: short dependency chains that a very small reservation-station entry can run as one unit. It keeps a parser stack that mirrors, at parse time, the operand stack such an entry would hold.

Operands (immediates and loads from architectural stack slots) are pushed as single items. An operation pops its inputs and fuses them with its own token. Every item left below that point is flushed out as its own hyperblock. A one-result operation keeps the fused chain as the only parser-stack item. A no-result operation sends the chain out. Anything else flushes the parser stack and leaves as a lone token. Because every operation flushes, no hyperblock ever holds two independent sub-expressions or a stack permutation.

The output is a token stream, one token per cycle. A last flag closes each hyperblock. Input is stalled while tokens are being streamed.

Top module: `hyperblock_grouper`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and the parser stack is empty.
- R2: An operand (class code 0) accepted while the parser stack holds fewer than DEPTH items produces no output and leaves `in_ready` high.
- R3: A one-result operation (class code 1) whose arity equals the item count fuses every item, in stack order, with its own token. It emits nothing, and the fused chain later leaves as one hyperblock with `out_last` only on the operation token.
- R4: When an operation's arity N is smaller than the item count, the items below the top N leave first, bottom first, each as its own hyperblock; for a one-result operation the fused chain stays.
- R5: A no-result operation (class code 2) emits the leftover items, then the fused chain (popped tokens then the operation, last flag on the operation), and leaves the parser stack empty.
- R6: An instruction of class code 3 flushes all items individually, then leaves as a single-token hyperblock.
- R7: An operation whose arity exceeds the item count flushes the parser stack and leaves as a single-token hyperblock.
- R8: An operation whose fused chain would exceed MAX_LEN tokens flushes the parser stack and leaves as a single-token hyperblock.
- R9: An operand arriving when DEPTH items are held flushes all items individually, and then becomes the only item.
- R10: While `out_valid` is high and `out_ready` low, `out_valid`, `out_payload` and `out_last` hold, and `in_ready` stays low while tokens are pending.
- R11: The first emitted token is presented in the cycle after the accepting edge, tokens follow with no gaps while `out_ready` is high, and `in_ready` is high in the cycle after the final token is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| in_cls | input | 2 | 0 operand, 1 one-result op, 2 no-result op, 3 other |
| in_arity | input | ARITY_W | Number of inputs of an operation |
| in_payload | input | PAYLOAD_W | Opaque instruction token |
| out_valid | output | 1 | Token offered |
| out_ready | input | 1 | Consumer takes the token |
| out_payload | output | PAYLOAD_W | Token contents |
| out_last | output | 1 | Token closes its hyperblock |

## Verification
Every emitted token is due from the cycle after the edge that accepted the instruction causing it. The tokens then follow back to back whenever the consumer is ready. Pushes that fit, and operations that consume the whole stack, must leave the output idle. The bench advances a behavioural parser-stack model on each accepting edge and keeps a queue of expected tokens. At every falling edge it requires `out_valid` to equal "queue not empty" and `in_ready` to equal "queue empty", and it compares the head token and its last flag, so both the contents and the exact cycle of each result are checked.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    HB_PUSH    = 2'd0,
    HB_OP_ONE  = 2'd1,
    HB_OP_NONE = 2'd2,
    HB_OTHER   = 2'd3
  } hb_cls_e;
endpackage

// File: rtl/hbg_rst_sync.sv
module hbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/hbg_plan.sv
// Decides, for the offered instruction, how the parser stack is split.
module hbg_plan import hbg_pkg::*; #(
  parameter int DEPTH   = 4,
  parameter int MAX_LEN = 6,
  parameter int ARITY_W = 3,
  parameter int CW      = 4
) (
  input  hb_cls_e            cls,
  input  logic [ARITY_W-1:0] arity,
  input  logic [CW-1:0]      ntok,
  input  logic [CW-1:0]      blen,
  output logic [CW-1:0]      nitem,
  output logic               plain,
  output logic               keep,
  output logic [CW-1:0]      split
);
  localparam int XW = ((CW > ARITY_W) ? CW : ARITY_W) + 1;

  logic [XW-1:0] ntok_x, nitem_x, ar_x, sp_x, len_x;

  always_comb begin
    nitem   = (ntok == '0) ? '0 : (ntok - blen + CW'(1));
    ntok_x  = XW'(ntok);
    nitem_x = XW'(nitem);
    ar_x    = XW'(arity);
    sp_x    = (ar_x == nitem_x) ? '0 : (ntok_x - ar_x);
    len_x   = ntok_x - sp_x + XW'(1);
    plain   = 1'b0;
    keep    = 1'b0;
    split   = ntok;
    unique case (cls)
      HB_PUSH: begin
        if (nitem_x < XW'(DEPTH)) plain = 1'b1;
        else                      keep  = 1'b1;
      end
      HB_OP_ONE, HB_OP_NONE: begin
        if (ar_x <= nitem_x && len_x <= XW'(MAX_LEN)) begin
          keep  = (cls == HB_OP_ONE);
          split = CW'(sp_x);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hbg_store.sv
// Flat token store: bottom chain first, single operands above it.
module hbg_store #(
  parameter int PAYLOAD_W = 16,
  parameter int CAP       = 10,
  parameter int CW        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PAYLOAD_W-1:0] wr_data,
  input  logic                 cnt_we,
  input  logic [CW-1:0]        cnt_d,
  input  logic [CW-1:0]        blen_d,
  input  logic                 sh_en,
  input  logic [CW-1:0]        sh_amt,
  input  logic [CW-1:0]        rd_idx,
  output logic [CW-1:0]        ntok,
  output logic [CW-1:0]        blen,
  output logic [PAYLOAD_W-1:0] rd_data
);
  logic [PAYLOAD_W-1:0] tok_q [CAP];
  logic [PAYLOAD_W-1:0] tok_d [CAP];
  logic                 tok_en;
  logic [CW-1:0]        ntok_q, blen_q;

  assign tok_en = wr_en | sh_en;

  always_comb begin
    tok_d = tok_q;
    for (int j = 0; j < CAP; j++) begin
      if (wr_en && ntok_q == CW'(j)) tok_d[j] = wr_data;
      if (sh_en) begin
        tok_d[j] = '0;
        for (int k = 0; k < CAP; k++) begin
          if ((CW+1)'(k) == (CW+1)'(j) + {1'b0, sh_amt}) tok_d[j] = tok_q[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tok_en) tok_q <= tok_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntok_q <= '0;
      blen_q <= '0;
    end else if (cnt_we) begin
      ntok_q <= cnt_d;
      blen_q <= blen_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < CAP; k++) begin
      if (rd_idx == CW'(k)) rd_data = tok_q[k];
    end
  end

  assign ntok = ntok_q;
  assign blen = blen_q;
endmodule

// File: rtl/hbg_drain.sv
// Streams tokens out of the store and marks hyperblock ends.
module hbg_drain #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] split_in,
  input  logic [CW-1:0] total_in,
  input  logic          keep_in,
  input  logic [CW-1:0] blen,
  input  logic          out_ready,
  output logic          busy,
  output logic          out_valid,
  output logic          out_last,
  output logic [CW-1:0] rd_idx,
  output logic          done,
  output logic          keep_q,
  output logic [CW-1:0] split_q,
  output logic [CW-1:0] total_q
);
  logic          busy_q, busy_d;
  logic [CW-1:0] rd_q, rd_d;
  logic [CW-1:0] split_d, total_d;
  logic          keep_d;
  logic [CW-1:0] end_c;
  logic          fire, ctl_en;

  always_comb begin
    end_c = keep_q ? split_q : total_q;
    fire  = busy_q & out_ready;
    done  = fire && (({1'b0, rd_q} + 1'b1) == {1'b0, end_c});
    if (rd_q < split_q) out_last = (({1'b0, rd_q} + 1'b1) >= {1'b0, blen});
    else                out_last = (({1'b0, rd_q} + 1'b1) == {1'b0, total_q});
  end

  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    split_d = split_q;
    total_d = total_q;
    keep_d  = keep_q;
    if (start) begin
      busy_d  = 1'b1;
      rd_d    = '0;
      split_d = split_in;
      total_d = total_in;
      keep_d  = keep_in;
    end else if (fire) begin
      rd_d = rd_q + CW'(1);
      if (done) busy_d = 1'b0;
    end
  end

  assign ctl_en = start | fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= '0;
      split_q <= '0;
      total_q <= '0;
      keep_q  <= 1'b0;
    end else if (ctl_en) begin
      busy_q  <= busy_d;
      rd_q    <= rd_d;
      split_q <= split_d;
      total_q <= total_d;
      keep_q  <= keep_d;
    end
  end

  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign rd_idx    = rd_q;
endmodule

// File: rtl/hyperblock_grouper.sv
module hyperblock_grouper import hbg_pkg::*; #(
  parameter int PAYLOAD_W = 16,
  parameter int ARITY_W   = 3,
  parameter int DEPTH     = 4,
  parameter int MAX_LEN   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_cls,
  input  logic [ARITY_W-1:0]   in_arity,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PAYLOAD_W-1:0] out_payload,
  output logic                 out_last
);
  localparam int CAP = MAX_LEN + DEPTH;
  localparam int CW  = $clog2(CAP + 1);

  logic          rst_n_s;
  logic [CW-1:0] ntok, blen, nitem, split, rd_idx;
  logic          plain, keep, busy, done, keep_q;
  logic [CW-1:0] split_q, total_q;
  logic          accept, immed_keep, start;
  logic          cnt_we, sh_en;
  logic [CW-1:0] cnt_d, blen_d, kept_len;

  hbg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  hbg_plan #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .ARITY_W(ARITY_W), .CW(CW)) u_plan (
    .cls(hb_cls_e'(in_cls)), .arity(in_arity), .ntok(ntok), .blen(blen),
    .nitem(nitem), .plain(plain), .keep(keep), .split(split)
  );

  assign in_ready   = rst_n_s & ~busy;
  assign accept     = in_valid & in_ready;
  assign immed_keep = keep & (split == '0);
  assign start      = accept & ~plain & ~immed_keep;
  assign kept_len   = total_q - split_q;
  assign sh_en      = done & keep_q;

  always_comb begin
    cnt_we = 1'b0;
    cnt_d  = ntok;
    blen_d = blen;
    if (done) begin
      cnt_we = 1'b1;
      cnt_d  = keep_q ? kept_len : '0;
      blen_d = keep_q ? kept_len : '0;
    end else if (accept && plain) begin
      cnt_we = 1'b1;
      cnt_d  = ntok + CW'(1);
      blen_d = (ntok == '0) ? CW'(1) : blen;
    end else if (accept && immed_keep) begin
      cnt_we = 1'b1;
      cnt_d  = ntok + CW'(1);
      blen_d = ntok + CW'(1);
    end
  end

  hbg_store #(.PAYLOAD_W(PAYLOAD_W), .CAP(CAP), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(accept), .wr_data(in_payload),
    .cnt_we(cnt_we), .cnt_d(cnt_d), .blen_d(blen_d),
    .sh_en(sh_en), .sh_amt(split_q),
    .rd_idx(rd_idx), .ntok(ntok), .blen(blen), .rd_data(out_payload)
  );

  hbg_drain #(.CW(CW)) u_drain (
    .clk(clk), .rst_n(rst_n_s), .start(start),
    .split_in(split), .total_in(ntok + CW'(1)), .keep_in(keep),
    .blen(blen), .out_ready(out_ready),
    .busy(busy), .out_valid(out_valid), .out_last(out_last),
    .rd_idx(rd_idx), .done(done),
    .keep_q(keep_q), .split_q(split_q), .total_q(total_q)
  );
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int PAYLOAD_W = 16,
  parameter int ARITY_W   = 3,
  parameter int CW        = 4,
  parameter int DEPTH     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [1:0]           in_cls,
  input logic [ARITY_W-1:0]   in_arity,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [PAYLOAD_W-1:0] out_payload,
  input logic                 out_last,
  input logic [CW-1:0]        nitem
);
  logic take;
  assign take = in_valid & in_ready;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_payload) && $stable(out_last));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_push_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_cls == 2'd0 && nitem < CW'(DEPTH) |=> !out_valid);

  p_other_emits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_cls == 2'd3 |=> out_valid);

  p_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_cls == 2'd1 || in_cls == 2'd2) &&
    ({{CW{1'b0}}, in_arity} > {{ARITY_W{1'b0}}, nitem}) |=> out_valid);

  p_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> nitem <= CW'(DEPTH));

  p_ready_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> in_ready);
endmodule

bind hyperblock_grouper hbg_checker #(
  .PAYLOAD_W(PAYLOAD_W), .ARITY_W(ARITY_W), .CW(CW), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_ready(in_ready),
  .in_cls(in_cls), .in_arity(in_arity), .out_valid(out_valid),
  .out_ready(out_ready), .out_payload(out_payload), .out_last(out_last),
  .nitem(nitem)
);

// File: tb/tb_hyperblock_grouper.sv
`timescale 1ns/1ps
module tb_hyperblock_grouper;
  localparam int PW = 16, AW = 3, DEPTH = 4, MAXL = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, in_valid, in_ready, out_valid, out_ready, out_last;
  logic [1:0]    in_cls;
  logic [AW-1:0] in_arity;
  logic [PW-1:0] in_payload, out_payload;

  hyperblock_grouper #(.PAYLOAD_W(PW), .ARITY_W(AW), .DEPTH(DEPTH), .MAX_LEN(MAXL)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_arity(in_arity), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_payload(out_payload),
    .out_last(out_last)
  );

  int    checks = 0, errors = 0;
  string req = "R1";
  bit    live = 0, rnd_ready = 0;
  bit    prev_stall = 0, prev_last = 0;
  int    prev_pay = 0;

  int tq[$];
  int il[$];
  int eq[$];
  bit el[$];

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void emit(int p, bit l);
    eq.push_back(p);
    el.push_back(l);
  endfunction

  function automatic void flush_all();
    int pos;
    pos = 0;
    foreach (il[i]) begin
      for (int k = 0; k < il[i]; k++) begin
        emit(tq[pos], k == il[i] - 1);
        pos++;
      end
    end
    tq.delete();
    il.delete();
  endfunction

  function automatic void model_step(int c, int a, int p);
    int nit, len;
    int blk[$];
    nit = il.size();
    if (c == 0) begin
      if (nit >= DEPTH) flush_all();
      tq.push_back(p);
      il.push_back(1);
    end else if (c == 1 || c == 2) begin
      if (a > nit) begin
        flush_all();
        emit(p, 1);
      end else begin
        len = 0;
        for (int i = 0; i < a; i++) len += il[nit-1-i];
        if (len + 1 > MAXL) begin
          flush_all();
          emit(p, 1);
        end else begin
          for (int i = 0; i < len; i++) blk.push_front(tq.pop_back());
          for (int i = 0; i < a; i++) void'(il.pop_back());
          flush_all();
          if (c == 1) begin
            tq = blk;
            tq.push_back(p);
            il.push_back(len + 1);
          end else begin
            foreach (blk[i]) emit(blk[i], 0);
            emit(p, 1);
          end
        end
      end
    end else begin
      flush_all();
      emit(p, 1);
    end
  endfunction

  // per-cycle comparison against the model (R10, R11 timing)
  always @(negedge clk) begin
    if (live) begin
      if (prev_stall) begin
        chk(out_valid === 1'b1, "R10 valid held", int'(out_valid), 1);
        chk(int'(out_payload) == prev_pay, "R10 payload held", int'(out_payload), prev_pay);
        chk(out_last === prev_last, "R10 last held", int'(out_last), int'(prev_last));
      end
      chk(out_valid === (eq.size() > 0), "R11 out_valid timing", int'(out_valid), int'(eq.size() > 0));
      chk(in_ready === (eq.size() == 0), "R11 in_ready timing", int'(in_ready), int'(eq.size() == 0));
      prev_stall = out_valid && !out_ready;
      prev_pay   = int'(out_payload);
      prev_last  = out_last;
      if (out_valid === 1'b1 && eq.size() > 0) begin
        chk(int'(out_payload) == eq[0], "payload", int'(out_payload), eq[0]);
        chk(out_last === el[0], "last flag", int'(out_last), int'(el[0]));
        if (out_ready) begin
          void'(eq.pop_front());
          void'(el.pop_front());
        end
      end
      if (in_valid && in_ready) model_step(int'(in_cls), int'(in_arity), int'(in_payload));
    end
  end

  always @(posedge clk) begin
    #1 out_ready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic send(int c, int a, int p);
    in_valid   = 1'b1;
    in_cls     = c[1:0];
    in_arity   = a[AW-1:0];
    in_payload = p[PW-1:0];
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic settle();
    do @(negedge clk); while (eq.size() != 0);
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_cls = '0; in_arity = '0; in_payload = '0;
    out_ready = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    req = "R1";
    chk(out_valid === 1'b0, "reset out_valid", int'(out_valid), 0);
    chk(in_ready === 1'b1, "reset in_ready", int'(in_ready), 1);
    live = 1;
    @(posedge clk); #1;
    req = "R1";  send(3, 0, 16'h0F00); settle();         // empty stack: only the lone token
    req = "R2";  send(0, 0, 16'h0101); send(0, 0, 16'h0102); send(0, 0, 16'h0103);
    req = "R3";  send(1, 3, 16'h0104);                     // consumes all three
    req = "R6";  send(3, 0, 16'h0105); settle();
    req = "R4";  send(0, 0, 16'h0201); send(0, 0, 16'h0202); send(1, 2, 16'h0203);
                 send(0, 0, 16'h0204); send(0, 0, 16'h0205); send(0, 0, 16'h0206);
                 send(1, 2, 16'h0207); settle();
    req = "R5";  send(2, 1, 16'h0208); settle();
    req = "R5";  send(0, 0, 16'h0301); send(0, 0, 16'h0302); send(1, 2, 16'h0303);
                 send(0, 0, 16'h0304); send(0, 0, 16'h0305); send(0, 0, 16'h0306);
                 send(2, 1, 16'h0307); settle();
    req = "R7";  send(0, 0, 16'h0401); send(1, 2, 16'h0402); settle();
                 send(3, 0, 16'h0403); settle();
    req = "R8";  send(0, 0, 16'h0501); send(0, 0, 16'h0502); send(0, 0, 16'h0503);
                 send(0, 0, 16'h0504); send(1, 4, 16'h0505); send(0, 0, 16'h0506);
                 send(1, 2, 16'h0507); settle();
    req = "R9";  send(0, 0, 16'h0601); send(0, 0, 16'h0602); send(0, 0, 16'h0603);
                 send(0, 0, 16'h0604); send(0, 0, 16'h0605); settle();
                 send(2, 1, 16'h0606); settle();
    req = "R10"; rnd_ready = 1;
    for (int i = 0; i < 400; i++) begin
      int r, c, a;
      r = $urandom % 8;
      c = (r < 4) ? 0 : (r < 6) ? 1 : (r == 6) ? 2 : 3;
      a = $urandom % 6;
      send(c, a, 16'h1000 + i);
    end
    send(3, 0, 16'h0FFF);
    settle();
    rnd_ready = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule